// File: doc/BRIEF.md
# Level-Triggered Interrupt Redirection Table with End-of-Interrupt Clear

This block holds a small table of interrupt redirection entries, each fed by one level-sensitive request line. Software loads every entry with an 8-bit vector and a mask bit through a simple register write port. An unmasked entry whose line is high and which has no interrupt in service offers a message carrying its vector and entry index. When the message is taken, the entry sets its in-service flag and stays silent until software retires it.

Software retires service by writing a vector to the end-of-interrupt register. The block compares that vector with every entry at once. Each entry that matches drops its in-service flag in the same cycle. An entry whose line is still high then offers its message again without further action. If several entries share one vector, one write retires all of them, even an entry that was not yet serviced. That request is not lost, because a line that stays asserted requests again.

Top module: `irq_redir_table`

## Requirements
- R1: After reset every entry is masked, its vector is 00h and its in-service flag is clear. msg_valid stays low even with every request line high.
- R2: A write to address CFG_BASE + 4*i loads entry i. Data bits 7:0 become the vector and data bit 16 becomes the mask (1 = masked). A write to any address that is neither an entry address nor the end-of-interrupt address changes nothing.
- R3: An entry is eligible when its request line is high, its mask is 0 and its in-service flag is clear. msg_valid is high in any cycle in which at least one entry is eligible.
- R4: When several entries are eligible, the one with the lowest index is offered. msg_vector and msg_index carry that entry's vector and index.
- R5: A clock edge with msg_valid and msg_ready both high sets the in-service flag of the offered entry. While that flag is set, the entry is not offered.
- R6: A write to address 40h is an end-of-interrupt. Data bits 7:0 hold the vector and bits 31:8 are ignored. Every entry whose vector equals it has its in-service flag cleared on that edge.
- R7: An end-of-interrupt leaves the in-service flag of every entry whose vector does not match.
- R8: An entry whose request line is still high and which is unmasked is offered again in the cycle after its in-service flag is cleared.
- R9: If an end-of-interrupt that matches an entry falls on the same edge as the acceptance of that entry's message, the acceptance wins and the flag stays set.
- R10: A masked entry is never offered, whatever its request line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register byte address |
| wr_data | input | DATA_W (32) | Register write data |
| irq_lvl | input | NUM_ENTRIES (8) | Level request line per entry |
| msg_valid | output | 1 | An interrupt message is offered |
| msg_ready | input | 1 | Receiver takes the offered message |
| msg_vector | output | VEC_W (8) | Vector of the offered entry |
| msg_index | output | IDX_W (3) | Index of the offered entry |

## Verification
The assertions assume that the request lines and msg_ready are stable around the clock edge, and that msg_ready alone decides acceptance. Nothing is assumed about how long a line stays high. The bench drives every input on the falling edge and reads the outputs just before the next rising edge. Each scenario starts from a fresh reset, so no in-service flag or mask carries over from an earlier case. Simultaneous events, such as an acceptance and a matching end-of-interrupt on one edge, are created by setting both inputs in the same half-cycle.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
   // bit of the entry configuration word that holds the mask
   localparam int unsigned CFG_MASK_BIT = 16;
   // spacing of entry configuration words in the register window
   localparam int unsigned CFG_STRIDE   = 4;
endpackage

// File: rtl/irq_entry.sv
module irq_entry #(
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [VEC_W-1:0] cfg_vec,
   input  logic             cfg_mask,
   input  logic             eoi_we,
   input  logic [VEC_W-1:0] eoi_vec,
   input  logic             accept,
   input  logic             irq,
   output logic [VEC_W-1:0] vec,
   output logic             masked,
   output logic             in_service,
   output logic             eligible
);
   logic eoi_hit;

   assign eoi_hit  = eoi_we && (eoi_vec == vec);
   assign eligible = irq && !masked && !in_service;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec    <= '0;
         masked <= 1'b1;
      end else if (cfg_we) begin
         vec    <= cfg_vec;
         masked <= cfg_mask;
      end
   end

   // acceptance has precedence over a matching end-of-interrupt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         in_service <= 1'b0;
      else if (accept)
         in_service <= 1'b1;
      else if (eoi_hit)
         in_service <= 1'b0;
   end

   // R6
   eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !accept) |=> !in_service);
   // R9
   accept_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> in_service);
   // R5
   set_only_by_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_service) |-> $past(accept));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned N = 8,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             any
);
   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt     = '0;
            gnt[i]  = 1'b1;
            gnt_idx = IDX_W'(i);
         end
      end
   end

   assign any = |req;

   // R4
   gnt_onehot_chk: assert property (@(req) ##0 $onehot0(gnt) && (any == (gnt != '0)));
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
   import irq_redir_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CFG_BASE    = 'h00,
   parameter int unsigned EOI_OFFSET  = 'h40,
   localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      wr_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [NUM_ENTRIES-1:0] irq_lvl,
   output logic                   msg_valid,
   input  logic                   msg_ready,
   output logic [VEC_W-1:0]       msg_vector,
   output logic [IDX_W-1:0]       msg_index
);
   localparam int unsigned CFG_END = CFG_BASE + CFG_STRIDE * NUM_ENTRIES;

   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("irq_redir_table: NUM_ENTRIES must be at least 2");
   end
   if (DATA_W <= CFG_MASK_BIT || VEC_W > DATA_W) begin : g_bad_data
      $error("irq_redir_table: DATA_W too narrow for vector and mask");
   end
   if (EOI_OFFSET >= CFG_BASE && EOI_OFFSET < CFG_END) begin : g_bad_map
      $error("irq_redir_table: EOI_OFFSET overlaps entry window");
   end
   if (CFG_END > (1 << ADDR_W) || EOI_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_redir_table: register window exceeds ADDR_W");
   end

   logic                   eoi_we;
   logic [NUM_ENTRIES-1:0] cfg_we;
   logic [NUM_ENTRIES-1:0] eligible;
   logic [NUM_ENTRIES-1:0] gnt;
   logic [NUM_ENTRIES-1:0] accept;
   logic [NUM_ENTRIES-1:0] masked;
   logic [NUM_ENTRIES-1:0] in_service;
   logic [VEC_W-1:0]       vec [NUM_ENTRIES];
   logic                   any;

   assign eoi_we = wr_en && (wr_addr == ADDR_W'(EOI_OFFSET));

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
      assign cfg_we[i] = wr_en && (wr_addr == ADDR_W'(CFG_BASE + CFG_STRIDE * i));
      assign accept[i] = gnt[i] && msg_ready;

      irq_entry #(.VEC_W(VEC_W)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_we     (cfg_we[i]),
         .cfg_vec    (wr_data[VEC_W-1:0]),
         .cfg_mask   (wr_data[CFG_MASK_BIT]),
         .eoi_we     (eoi_we),
         .eoi_vec    (wr_data[VEC_W-1:0]),
         .accept     (accept[i]),
         .irq        (irq_lvl[i]),
         .vec        (vec[i]),
         .masked     (masked[i]),
         .in_service (in_service[i]),
         .eligible   (eligible[i])
      );
   end

   irq_prio_arb #(.N(NUM_ENTRIES)) u_arb (
      .req     (eligible),
      .gnt     (gnt),
      .gnt_idx (msg_index),
      .any     (any)
   );

   assign msg_valid  = any;
   assign msg_vector = vec[msg_index];

   // R3
   offer_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (irq_lvl[msg_index] && !masked[msg_index] && !in_service[msg_index]));
   // R10
   masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !masked[msg_index]);
   // R5
   take_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> in_service[$past(msg_index)]);
   // R7
   nonmatch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_we && in_service[0] && wr_data[VEC_W-1:0] != vec[0]) |=> in_service[0]);
endmodule

// File: tb/tb_irq_redir_table.sv
module tb_irq_redir_table;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;
   logic [N-1:0] irq_lvl;
   logic        msg_valid;
   logic        msg_ready;
   logic [7:0]  msg_vector;
   logic [2:0]  msg_index;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_redir_table dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .irq_lvl(irq_lvl), .msg_valid(msg_valid),
      .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_index(msg_index)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // sample just before the next rising edge
   task automatic settle();
      @(negedge clk);
      #3;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      irq_lvl = '0; msg_ready = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic reg_wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(int idx, logic [7:0] v, logic m);
      reg_wr(8'(idx * 4), {15'b0, m, 8'b0, v});
   endtask

   task automatic take();
      @(negedge clk);
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      irq_lvl = '1;
      settle();
      check("R1 valid after reset", msg_valid, 0);
      check("R10 masked all high", msg_valid, 0);
   endtask

   task automatic t_single();
      do_reset();
      cfg(2, 8'h33, 1'b0);
      irq_lvl[2] = 1'b1;
      settle();
      check("R3 valid", msg_valid, 1);
      check("R2 vector", msg_vector, 8'h33);
      check("R4 index", msg_index, 2);
      take();
      settle();
      check("R5 silent in service", msg_valid, 0);
      reg_wr(8'h40, 32'hABCDEF33);
      settle();
      check("R6 upper bits ignored, cleared", msg_valid, 1);
      check("R8 refire vector", msg_vector, 8'h33);
   endtask

   task automatic t_prio();
      do_reset();
      cfg(5, 8'h55, 1'b0);
      cfg(1, 8'h11, 1'b0);
      irq_lvl = 8'b0010_0010;
      settle();
      check("R4 lowest index", msg_index, 1);
      check("R4 lowest vector", msg_vector, 8'h11);
      take();
      settle();
      check("R4 next index", msg_index, 5);
      check("R4 next vector", msg_vector, 8'h55);
   endtask

   task automatic t_shared();
      do_reset();
      cfg(3, 8'h50, 1'b0);
      cfg(4, 8'h50, 1'b0);
      cfg(6, 8'h60, 1'b0);
      irq_lvl = 8'b0101_1000;
      take(); take(); take();
      settle();
      check("R5 all in service", msg_valid, 0);
      reg_wr(8'h40, 32'h0000_0050);
      settle();
      check("R6 shared cleared idx", msg_index, 3);
      take();
      settle();
      check("R6 second shared cleared", msg_index, 4);
      take();
      settle();
      check("R7 nonmatching kept", msg_valid, 0);
   endtask

   task automatic t_race();
      do_reset();
      cfg(0, 8'h77, 1'b0);
      irq_lvl[0] = 1'b1;
      take();
      reg_wr(8'h40, 32'h77);
      settle();
      check("R8 refire idx0", msg_valid, 1);
      @(negedge clk);
      msg_ready = 1'b1; wr_en = 1'b1; wr_addr = 8'h40; wr_data = 32'h77;
      @(negedge clk);
      msg_ready = 1'b0; wr_en = 1'b0;
      settle();
      check("R9 accept wins", msg_valid, 0);
   endtask

   task automatic t_stray();
      do_reset();
      cfg(1, 8'h21, 1'b0);
      reg_wr(8'h44, 32'h0000_0099);
      reg_wr(8'h06, 32'h0000_0099);
      irq_lvl[1] = 1'b1;
      settle();
      check("R2 stray write ignored", msg_vector, 8'h21);
      cfg(1, 8'h21, 1'b1);
      settle();
      check("R10 remasked silent", msg_valid, 0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_single();
            t_prio();
            t_shared();
            t_race();
            t_stray();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule